// File: doc/BRIEF.md
# Overflow-Interval Load Estimator

This block turns the overflow events of preloaded event counters on several memory channels into a coarse utilisation figure for a frequency governor. It does not count events itself. It runs a free timestamp that advances by a fixed step each clock, so that one unit is roughly one nanosecond. It also keeps, for each channel, the timestamp of that channel's most recent overflow. Each overflow is serviced in turn. The block takes the time elapsed since the serviced channel's previous overflow and compares it with a limit. A short interval means heavy traffic and gives a high busy figure; a long interval gives a low one. The result is a fast step up and a slow step down.

Every evaluation stops the event counters, reloads them with a fixed start value and starts them again. The block drives a run level, a one-cycle restart pulse and the start value to the counters. The busy and total figures come with a one-cycle valid pulse that the governor samples. While the enable input is low, the block is idle and ignores all overflows. When enable rises, the block takes the current time as the stamp for every channel and reports a near-full estimate as a safe starting point.

Top module: `ole_load_estimator`

## Requirements
- R1: While reset is asserted, busy_o, total_o, est_valid_o, restart_o and run_o are all zero.
- R2: On the first clock with enable_i high after a low period, every channel's stamp is set to the current time. In the same cycle busy_o=99 and total_o=100 are presented with a one-cycle est_valid_o and restart_o pulse, and run_o goes high.
- R3: If the serviced channel's interval, in timestamp units, is below LIMIT, the result is busy_o=70, total_o=100.
- R4: If that interval is at or above LIMIT, the result is busy_o=35, total_o=100.
- R5: The timestamp grows by STEP per clock. An interval is the unsigned difference modulo 2^TS_W, so it stays correct across a timestamp wrap as long as the true interval is below 2^TS_W.
- R6: Bit i of ovf_i belongs to channel i. When several channels are pending, the lowest index is serviced first, so channel 0 wins over channel 1.
- R7: A service updates only the serviced channel's stamp. The other channels keep measuring from their own last overflow.
- R8: An overflow that arrives while a service is in progress is held pending and serviced afterwards. This also holds for a second overflow of the channel that is being serviced.
- R9: During each service run_o is low for exactly one cycle. It then returns high together with a one-cycle restart_o pulse, and preload_o holds 0xFF000000.
- R10: While enable_i is low, run_o and est_valid_o stay low and overflows are discarded. Overflows seen while disabled are not serviced after a later enable.
- R11: An overflow sampled at clock edge k with nothing else pending is taken at edge k+1, with run_o low after k+1. The result appears after edge k+2 with est_valid_o high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Estimator enable |
| ovf_i | input | NCH | Per-channel overflow pulses, bit i = channel i |
| busy_o | output | VAL_W | Busy figure of the latest estimate |
| total_o | output | VAL_W | Total figure of the latest estimate |
| est_valid_o | output | 1 | One-cycle pulse when busy_o/total_o are updated |
| restart_o | output | 1 | One-cycle pulse: reload counters with preload_o and start |
| run_o | output | 1 | Counters may run (low while stopped) |
| preload_o | output | CNT_W | Counter start value |

## Verification
The bench sweeps the interval, measured in clocks, across the limit in both directions while it alternates the channels. An off-by-one in the comparison or in the service latency moves the 70/35 edge by one step. The same stimulus drives a second copy with a 10-bit timestamp that wraps many times, which exposes a signed or saturating difference. Both channels are raised in one cycle, and a channel is raised again during its own service. This catches a wrong priority, a dropped pending flag, or a stamp written for both channels. A disable window full of overflows checks that nothing leaks into the next enable.

// File: rtl/ole_pkg.sv
package ole_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_EVAL = 2'd2
    } ole_state_e;

endpackage

// File: rtl/ole_timebase.sv
module ole_timebase #(
    parameter int TS_W = 64,
    parameter int STEP = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_o
);
    localparam logic [TS_W-1:0] INC = TS_W'(STEP);

    logic [TS_W-1:0] ts_d, ts_q;

    always_comb begin
        ts_d = ts_q + INC;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign ts_o = ts_q;
endmodule

// File: rtl/ole_pend_arb.sv
module ole_pend_arb #(
    parameter int NCH   = 2,
    parameter int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [NCH-1:0]   ovf_i,
    input  logic             take_i,
    output logic             pend_any_o,
    output logic [NCH-1:0]   grant_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [NCH-1:0] pend_d, pend_q;
    logic [NCH-1:0] grant;
    logic [IDX_W-1:0] idx;

    // lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (!en_i) pend_d = '0;
        else       pend_d = (pend_q & ~(take_i ? grant : '0)) | ovf_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_any_o = |pend_q;
    assign grant_o    = grant;
    assign idx_o      = idx;
endmodule

// File: rtl/ole_stamp_bank.sv
module ole_stamp_bank #(
    parameter int NCH   = 2,
    parameter int TS_W  = 64,
    parameter int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  now_i,
    input  logic             load_all_i,
    input  logic             load_one_i,
    input  logic [IDX_W-1:0] sel_i,
    output logic [TS_W-1:0]  diff_o
);
    logic [TS_W-1:0] last_w [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [TS_W-1:0] stamp_d, stamp_q;

        always_comb begin
            stamp_d = stamp_q;
            if (load_all_i || (load_one_i && (sel_i == IDX_W'(g))))
                stamp_d = now_i;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) stamp_q <= '0;
            else        stamp_q <= stamp_d;
        end

        assign last_w[g] = stamp_q;
    end

    logic [TS_W-1:0] sel_last;

    always_comb begin
        sel_last = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel_i == IDX_W'(i)) sel_last = last_w[i];
        end
    end

    // modulo difference keeps intervals right across a wrap
    assign diff_o = now_i - sel_last;
endmodule

// File: rtl/ole_load_estimator.sv
module ole_load_estimator #(
    parameter int              NCH       = 2,
    parameter int              TS_W      = 64,
    parameter int              STEP      = 20,
    parameter longint unsigned LIMIT     = 64'd900000000,
    parameter int              VAL_W     = 8,
    parameter int              BUSY_HI   = 70,
    parameter int              BUSY_LO   = 35,
    parameter int              BUSY_INIT = 99,
    parameter int              TOTAL     = 100,
    parameter int              CNT_W     = 32,
    parameter longint unsigned PRELOAD   = 64'hFF000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [NCH-1:0]   ovf_i,
    output logic [VAL_W-1:0] busy_o,
    output logic [VAL_W-1:0] total_o,
    output logic             est_valid_o,
    output logic             restart_o,
    output logic             run_o,
    output logic [CNT_W-1:0] preload_o
);
    import ole_pkg::*;

    localparam int               IDX_W    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [TS_W-1:0]  LIMIT_TS = TS_W'(LIMIT);
    localparam logic [VAL_W-1:0] HI_V     = VAL_W'(BUSY_HI);
    localparam logic [VAL_W-1:0] LO_V     = VAL_W'(BUSY_LO);
    localparam logic [VAL_W-1:0] INIT_V   = VAL_W'(BUSY_INIT);
    localparam logic [VAL_W-1:0] TOT_V    = VAL_W'(TOTAL);

    typedef struct packed {
        ole_state_e       st;
        logic [TS_W-1:0]  diff;
        logic [VAL_W-1:0] busy;
        logic [VAL_W-1:0] total;
        logic             valid;
        logic             restart;
        logic             run;
    } est_reg_t;

    est_reg_t r_d, r_q;

    logic [TS_W-1:0]  now_w;
    logic [TS_W-1:0]  diff_w;
    logic             pend_any_w;
    logic [NCH-1:0]   grant_w;
    logic [IDX_W-1:0] idx_w;
    logic             take_w, load_all_w, load_one_w;

    ole_timebase #(.TS_W(TS_W), .STEP(STEP)) u_time (
        .clk  (clk),
        .rst_n(rst_n),
        .ts_o (now_w)
    );

    ole_pend_arb #(.NCH(NCH), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (enable_i),
        .ovf_i     (ovf_i),
        .take_i    (take_w),
        .pend_any_o(pend_any_w),
        .grant_o   (grant_w),
        .idx_o     (idx_w)
    );

    ole_stamp_bank #(.NCH(NCH), .TS_W(TS_W), .IDX_W(IDX_W)) u_stamps (
        .clk       (clk),
        .rst_n     (rst_n),
        .now_i     (now_w),
        .load_all_i(load_all_w),
        .load_one_i(load_one_w),
        .sel_i     (idx_w),
        .diff_o    (diff_w)
    );

    always_comb begin
        r_d         = r_q;
        r_d.valid   = 1'b0;
        r_d.restart = 1'b0;
        take_w      = 1'b0;
        load_all_w  = 1'b0;
        load_one_w  = 1'b0;
        if (!enable_i) begin
            r_d.st  = ST_OFF;
            r_d.run = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_OFF: begin
                    r_d.st      = ST_IDLE;
                    r_d.busy    = INIT_V;
                    r_d.total   = TOT_V;
                    r_d.valid   = 1'b1;
                    r_d.restart = 1'b1;
                    r_d.run     = 1'b1;
                    load_all_w  = 1'b1;
                end
                ST_IDLE: begin
                    if (pend_any_w) begin
                        take_w     = 1'b1;
                        load_one_w = 1'b1;
                        r_d.diff   = diff_w;
                        r_d.run    = 1'b0;
                        r_d.st     = ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    r_d.busy    = (r_q.diff < LIMIT_TS) ? HI_V : LO_V;
                    r_d.total   = TOT_V;
                    r_d.valid   = 1'b1;
                    r_d.restart = 1'b1;
                    r_d.run     = 1'b1;
                    r_d.st      = ST_IDLE;
                end
                default: r_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= ST_OFF;
            r_q.diff    <= '0;
            r_q.busy    <= '0;
            r_q.total   <= '0;
            r_q.valid   <= 1'b0;
            r_q.restart <= 1'b0;
            r_q.run     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = r_q.busy;
    assign total_o     = r_q.total;
    assign est_valid_o = r_q.valid;
    assign restart_o   = r_q.restart;
    assign run_o       = r_q.run;
    assign preload_o   = CNT_W'(PRELOAD);
endmodule

// File: rtl/ole_load_estimator_chk.sv
module ole_load_estimator_chk #(
    parameter int NCH       = 2,
    parameter int VAL_W     = 8,
    parameter int BUSY_HI   = 70,
    parameter int BUSY_LO   = 35,
    parameter int BUSY_INIT = 99,
    parameter int TOTAL     = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic             est_valid_o,
    input logic             restart_o,
    input logic             run_o,
    input logic [VAL_W-1:0] busy_o,
    input logic [VAL_W-1:0] total_o,
    input logic [NCH-1:0]   grant
);
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid_o |=> !est_valid_o);

    assert_restart_with_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid_o |-> (restart_o && run_o));

    assert_run_rise_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> restart_o);

    assert_total_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid_o |-> (total_o == VAL_W'(TOTAL)));

    assert_busy_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid_o |-> (busy_o == VAL_W'(BUSY_HI) || busy_o == VAL_W'(BUSY_LO)
                         || busy_o == VAL_W'(BUSY_INIT)));

    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!est_valid_o && !run_o));

    assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

bind ole_load_estimator ole_load_estimator_chk #(
    .NCH(NCH), .VAL_W(VAL_W), .BUSY_HI(BUSY_HI), .BUSY_LO(BUSY_LO),
    .BUSY_INIT(BUSY_INIT), .TOTAL(TOTAL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .est_valid_o(est_valid_o),
    .restart_o  (restart_o),
    .run_o      (run_o),
    .busy_o     (busy_o),
    .total_o    (total_o),
    .grant      (grant_w)
);

// File: tb/ole_load_estimator_test.sv
module ole_load_estimator_test;
    localparam int STEP  = 3;
    localparam int LIMIT = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] ovf = 2'b00;

    logic [7:0]  busy, total, busy_w, total_w;
    logic        valid, restart, run, valid_w, restart_w, run_w;
    logic [31:0] preload, preload_w;

    int tests = 0;
    int fails = 0;
    int edge_n = 0;
    int last [2];
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) edge_n <= edge_n + 1;

    ole_load_estimator #(.TS_W(64), .STEP(STEP), .LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .ovf_i(ovf),
        .busy_o(busy), .total_o(total), .est_valid_o(valid),
        .restart_o(restart), .run_o(run), .preload_o(preload));

    // narrow timestamp copy: wraps every 342 clocks
    ole_load_estimator #(.TS_W(10), .STEP(STEP), .LIMIT(LIMIT)) uut_wrap (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .ovf_i(ovf),
        .busy_o(busy_w), .total_o(total_w), .est_valid_o(valid_w),
        .restart_o(restart_w), .run_o(run_w), .preload_o(preload_w));

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_busy(input int d);
        return (STEP * d < LIMIT) ? 70 : 35;
    endfunction

    task automatic check_result(input string req, input int d);
        check(req, "valid", valid, 1);
        check(req, "busy", busy, exp_busy(d));
        check(req, "total", total, 100);
        check("R9", "restart", restart, 1);
        check("R9", "preload", preload, 32'hFF000000);
        if (STEP * d < 1024) begin
            check("R5", "wrap valid", valid_w, 1);
            check("R5", "wrap busy", busy_w, exp_busy(d));
        end
    endtask

    // overflow on channel ch about D clocks after its last service
    task automatic hit(input int ch, input int D, input string req);
        int target, k, d;
        target = last[ch] + D - 2;
        if (target < edge_n) target = edge_n;
        while (edge_n < target) @(negedge clk);
        ovf[ch] = 1'b1;
        k = edge_n + 1;
        d = (k + 1) - last[ch];
        @(negedge clk);
        ovf = 2'b00;
        @(negedge clk);
        check("R9", "run low in service", run, 0);
        check("R11", "no early valid", valid, 0);
        @(negedge clk);
        check_result(req, d);
        check("R9", "run back", run, 1);
        last[ch] = k + 1;
    endtask

    task automatic enable_now(input string req);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        check(req, "enable valid", valid, 1);
        check(req, "enable busy", busy, 99);
        check(req, "enable total", total, 100);
        check(req, "enable restart", restart, 1);
        check(req, "enable run", run, 1);
        check(req, "wrap enable busy", busy_w, 99);
        last[0] = edge_n;
        last[1] = edge_n;
        @(negedge clk);
        check("R11", "enable pulse one cycle", valid, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int k, d0, d1;
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", busy, 0);
        check("R1", "total in reset", total, 0);
        check("R1", "valid in reset", valid, 0);
        check("R1", "restart in reset", restart, 0);
        check("R1", "run in reset", run, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        enable_now("R2");

        // sweep across the limit, alternating channels (R3, R4, R7, R5)
        for (int i = 0; i < 42; i++)
            hit(i % 2, 90 + i / 2, (STEP * (90 + i / 2) < LIMIT) ? "R3" : "R4");

        // both channels at once: channel 0 first (R6)
        hit(0, 5, "R3");
        k = last[1] + 100;
        while (edge_n < k - 1) @(negedge clk);
        ovf = 2'b11;
        d0 = (k + 1) - last[0];
        d1 = (k + 3) - last[1];
        @(negedge clk);
        ovf = 2'b00;
        @(negedge clk);
        @(negedge clk);
        check_result("R6", d0);
        @(negedge clk);
        check("R6", "gap between results", valid, 0);
        @(negedge clk);
        check_result("R6", d1);
        check("R7", "channel 1 kept old stamp busy", busy, 35);
        last[0] = k + 1;
        last[1] = k + 3;

        // same channel again during its own service (R8)
        k = last[0] + 105;
        while (edge_n < k - 1) @(negedge clk);
        ovf = 2'b01;
        d0 = (k + 1) - last[0];
        @(negedge clk);
        @(negedge clk);
        ovf = 2'b00;
        @(negedge clk);
        check_result("R8", d0);
        @(negedge clk);
        check("R8", "gap", valid, 0);
        @(negedge clk);
        check_result("R8", 2);
        last[0] = k + 3;

        // disabled window full of overflows (R10)
        @(negedge clk);
        enable = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ovf = 2'b11;
        end
        @(negedge clk);
        ovf = 2'b00;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R10", "valid while off", valid, 0);
            check("R10", "run while off", run, 0);
        end
        enable_now("R2");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R10", "no stale service", valid, 0);
        end
        hit(0, 99, "R3");
        hit(1, 100, "R4");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule